// File: doc/BRIEF.md
# Transmit Bit-Repetition Rate Adapter

This block lets a transmit path whose serializer always runs at the top line rate carry a slower line rate. Each incoming bit is sent several times in a row, by a factor of 1, 2, 4 or 8. The effective rate is therefore the top rate divided by that factor, while the transmit clock and the serializer setup stay the same. Symbols reach the block already line-coded as 10-bit values. The block's output is a raw parallel word of fixed width (10, 20 or 40 bits) for a serializer whose own encoder is bypassed.

Several channels share one transmit clock. Each channel has its own repetition setting, its own input handshake and its own output word. Changing the setting on one channel leaves the others untouched. Input arrives as a group of `OUT_W/10` symbols, exactly one output word's worth at factor 1. A slower channel takes a new group only every `R` cycles, and an input-ready signal paces its source. When a channel needs data and none is offered, it sends a programmable 10-bit idle symbol, repeated like any other data. The block handles the transmit direction only and never oversamples received data.

Top module: `rr_tx_rate_adapter`

## Requirements
- R1: While reset is asserted and during the first cycle after release, every `tx_word` is zero. Every `in_ready` bit is high in the first cycle after release.
- R2: The two-bit ratio code of a channel selects the repetition factor R as follows: code 0 gives R=1, code 1 gives R=2, code 2 gives R=4 and code 3 gives R=8.
- R3: A group holds symbol k at bits `[10k+9:10k]`, and bit 0 is sent first. Across the R output words of a group, output bit position `p = slot*OUT_W + i` (bit i of the slot-th word) carries group bit `p / R`. Each input bit therefore occupies R consecutive output positions.
- R4: Every group occupies exactly R output cycles. `in_ready` of a channel is high only in the last of those R cycles, so for R>1 it is low for the R-1 cycles that follow an acceptance.
- R5: A group is taken only on a clock edge where both `in_valid` and `in_ready` of that channel are high. Data and valid offered while ready is low have no effect on the output.
- R6: The first word of an accepted group appears on `tx_word` after the second rising edge that follows the accepting edge is counted from it. In other words, it is visible in the cycle after the acceptance cycle's successor.
- R7: The ratio code is sampled only at a group boundary (the accepting edge or the idle-loading edge). A change during a group takes effect from the next group on.
- R8: At a boundary without valid input, the channel sends a group made of `cfg_idle` replicated `OUT_W/10` times, spread by the current ratio.
- R9: Traffic and ratio changes on one channel do not alter the output words or ready timing of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit word clock, shared by all channels |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idle | input | 10 | Idle symbol sent when no group is offered |
| cfg_ratio | input | 2*NUM_CH | Per-channel ratio code, channel c at bits [2c+1:2c] |
| in_valid | input | NUM_CH | Per-channel group valid |
| in_ready | output | NUM_CH | Per-channel request for the next group |
| in_data | input | OUT_W*NUM_CH | Per-channel symbol group, channel c at [OUT_W*c +: OUT_W] |
| tx_word | output | OUT_W*NUM_CH | Per-channel raw word to the serializer |

## Verification
A wrong slot count or a stale ratio shows at the ports within one group. It appears either as `in_ready` rising one cycle early or late, or as the second output word of a group repeating bits at the wrong stride. A group register loaded at the wrong time shows up as idle bits in place of offered data, or as offered data where idle was due. That error is visible two cycles after the faulty edge. Any leak between channels is caught by running a steady factor-1 stream on one channel while another changes factor mid-group, and comparing each of its words.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int SYM_W = 10;

    // Repetition factor code: R = 2**code
    typedef enum logic [1:0] {
        RPT_X1 = 2'd0,
        RPT_X2 = 2'd1,
        RPT_X4 = 2'd2,
        RPT_X8 = 2'd3
    } rpt_code_e;

    // Index of the final output slot of a group for a given code
    function automatic logic [2:0] final_slot(input logic [1:0] code);
        case (code)
            RPT_X1:  return 3'd0;
            RPT_X2:  return 3'd1;
            RPT_X4:  return 3'd3;
            default: return 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/rr_bit_spread.sv
module rr_bit_spread #(
    parameter int OUT_W = 20
) (
    input  logic [OUT_W-1:0] grp_i,
    input  logic [1:0]       code_i,
    input  logic [2:0]       slot_i,
    output logic [OUT_W-1:0] word_o
);
    localparam int PW = $clog2(8 * OUT_W) + 1;
    localparam int GW = $clog2(OUT_W);

    // Output position p maps to group bit p >> code
    always_comb begin
        logic [PW-1:0] pos;
        logic [PW-1:0] src;
        word_o = '0;
        for (int i = 0; i < OUT_W; i++) begin
            pos = PW'(slot_i) * PW'(OUT_W) + PW'(i);
            src = pos >> code_i;
            word_o[i] = grp_i[src[GW-1:0]];
        end
    end
endmodule

// File: rtl/rr_idle_fill.sv
module rr_idle_fill #(
    parameter int OUT_W = 20
) (
    input  logic [rr_pkg::SYM_W-1:0] idle_i,
    output logic [OUT_W-1:0]         grp_o
);
    localparam int SYMS = OUT_W / rr_pkg::SYM_W;

    for (genvar k = 0; k < SYMS; k++) begin : g_sym
        assign grp_o[k*rr_pkg::SYM_W +: rr_pkg::SYM_W] = idle_i;
    end
endmodule

// File: rtl/rr_lane.sv
module rr_lane #(
    parameter int OUT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ratio_i,
    input  logic [OUT_W-1:0] idle_grp_i,
    input  logic             valid_i,
    input  logic [OUT_W-1:0] data_i,
    output logic             ready_o,
    output logic [OUT_W-1:0] word_o
);
    typedef struct packed {
        logic [OUT_W-1:0] grp;
        logic [1:0]       code;
        logic [2:0]       slot;
        logic [OUT_W-1:0] word;
    } lane_t;

    lane_t            st_q, st_d;
    logic [OUT_W-1:0] spread_w;
    logic             at_edge;

    rr_bit_spread #(.OUT_W(OUT_W)) u_spread (
        .grp_i  (st_q.grp),
        .code_i (st_q.code),
        .slot_i (st_q.slot),
        .word_o (spread_w)
    );

    always_comb begin
        at_edge   = (st_q.slot == rr_pkg::final_slot(st_q.code));
        st_d      = st_q;
        st_d.word = spread_w;
        if (at_edge) begin
            st_d.slot = 3'd0;
            st_d.code = ratio_i;
            st_d.grp  = valid_i ? data_i : idle_grp_i;
        end else begin
            st_d.slot = st_q.slot + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = at_edge;
    assign word_o  = st_q.word;
endmodule

// File: rtl/rr_tx_rate_adapter.sv
module rr_tx_rate_adapter #(
    parameter int NUM_CH = 2,
    parameter int OUT_W  = 20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [rr_pkg::SYM_W-1:0]  cfg_idle,
    input  logic [2*NUM_CH-1:0]       cfg_ratio,
    input  logic [NUM_CH-1:0]         in_valid,
    output logic [NUM_CH-1:0]         in_ready,
    input  logic [OUT_W*NUM_CH-1:0]   in_data,
    output logic [OUT_W*NUM_CH-1:0]   tx_word
);
    logic [OUT_W-1:0] idle_grp;

    rr_idle_fill #(.OUT_W(OUT_W)) u_idle (
        .idle_i (cfg_idle),
        .grp_o  (idle_grp)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rr_lane #(.OUT_W(OUT_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .ratio_i    (cfg_ratio[2*c +: 2]),
            .idle_grp_i (idle_grp),
            .valid_i    (in_valid[c]),
            .data_i     (in_data[OUT_W*c +: OUT_W]),
            .ready_o    (in_ready[c]),
            .word_o     (tx_word[OUT_W*c +: OUT_W])
        );
    end
endmodule

// File: rtl/rr_tx_checker.sv
module rr_tx_checker #(
    parameter int NUM_CH = 2,
    parameter int OUT_W  = 20
) (
    input logic                    clk,
    input logic                    rst,
    input logic [2*NUM_CH-1:0]     cfg_ratio,
    input logic [NUM_CH-1:0]       in_ready,
    input logic [OUT_W*NUM_CH-1:0] tx_word
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(rst) |-> (tx_word == '0));

    assert_reset_ready_R1: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (&in_ready));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Boundary at factor 1: next cycle is again a boundary
        assert_x1_ready_R4: assert property (@(posedge clk) disable iff (rst)
            (in_ready[c] && cfg_ratio[2*c +: 2] == 2'd0) |=> in_ready[c]);

        // Any slower factor drops ready right after a boundary
        assert_slow_drop_R4: assert property (@(posedge clk) disable iff (rst)
            (in_ready[c] && cfg_ratio[2*c +: 2] != 2'd0) |=> !in_ready[c]);

        assert_x2_period_R2: assert property (@(posedge clk) disable iff (rst)
            (in_ready[c] && cfg_ratio[2*c +: 2] == 2'd1) |=> !in_ready[c] ##1 in_ready[c]);

        assert_x4_period_R7: assert property (@(posedge clk) disable iff (rst)
            (in_ready[c] && cfg_ratio[2*c +: 2] == 2'd2)
            |=> !in_ready[c] ##1 !in_ready[c] ##1 !in_ready[c] ##1 in_ready[c]);
    end
endmodule

bind rr_tx_rate_adapter rr_tx_checker #(.NUM_CH(NUM_CH), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_ratio (cfg_ratio),
    .in_ready  (in_ready),
    .tx_word   (tx_word)
);

// File: tb/sim_rr_tx_rate_adapter.sv
`timescale 1ns/1ps
module sim_rr_tx_rate_adapter;
    localparam int NCH = 2;
    localparam int W   = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [9:0]        cfg_idle = 10'h0;
    logic [2*NCH-1:0]  cfg_ratio = '0;
    logic [NCH-1:0]    in_valid = '0;
    logic [NCH-1:0]    in_ready;
    logic [W*NCH-1:0]  in_data = '0;
    logic [W*NCH-1:0]  tx_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    rr_tx_rate_adapter #(.NUM_CH(NCH), .OUT_W(W)) u0 (
        .clk(clk), .rst(rst), .cfg_idle(cfg_idle), .cfg_ratio(cfg_ratio),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .tx_word(tx_word)
    );

    // Expected word: output position p carries group bit p / R
    function automatic logic [W-1:0] exp_word(logic [W-1:0] g, logic [1:0] code, int s);
        logic [W-1:0] w;
        int r = 1 << code;
        for (int i = 0; i < W; i++) w[i] = g[(s * W + i) / r];
        return w;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One group (offered data or idle) through channel ch, checked word by word
    task automatic send(int ch, bit use_valid, logic [W-1:0] d, logic [1:0] code,
                        logic [1:0] next_code, bit junk, string req);
        logic [W-1:0] g;
        int r = 1 << code;
        @(negedge clk);
        cfg_ratio[2*ch +: 2] = code;
        while (!in_ready[ch]) @(negedge clk);
        in_valid[ch] = use_valid;
        in_data[W*ch +: W] = d;
        g = use_valid ? d : {2{cfg_idle}};
        @(negedge clk);
        in_valid[ch] = 1'b0;
        cfg_ratio[2*ch +: 2] = next_code;
        for (int s = 0; s < r; s++) begin
            @(negedge clk);
            check(req, tx_word[W*ch +: W], exp_word(g, code, s));
            if (s + 1 < r) check({req, " R4 ready"}, W'(in_ready[ch]), W'(s + 1 == r - 1));
            in_valid[ch] = junk && (s + 1 < r - 1);
            in_data[W*ch +: W] = ~d;
        end
        in_valid[ch] = 1'b0;
    endtask

    task automatic test_reset();
        check("R1 word ch0", tx_word[0 +: W], '0);
        check("R1 word ch1", tx_word[W +: W], '0);
        check("R1 ready", W'(in_ready), W'(2'b11));
    endtask

    task automatic test_ratio_sweep();
        send(0, 1, 20'hA5C3F, 2'd0, 2'd0, 0, "R2 R3 R6 x1");
        send(0, 1, 20'h3C96E, 2'd1, 2'd1, 0, "R2 R3 x2");
        send(0, 1, 20'h81F27, 2'd2, 2'd2, 0, "R2 R3 x4");
        send(0, 1, 20'hD2B49, 2'd3, 2'd3, 0, "R2 R3 x8");
    endtask

    task automatic test_handshake();
        send(0, 1, 20'h5A0F1, 2'd3, 2'd3, 1, "R5 junk x8");
        send(0, 1, 20'h0FF00, 2'd2, 2'd2, 1, "R5 junk x4");
    endtask

    task automatic test_idle();
        cfg_idle = 10'h2C7;
        send(1, 0, '0, 2'd1, 2'd1, 0, "R8 idle x2");
        cfg_idle = 10'h17C;
        send(1, 0, '0, 2'd3, 2'd3, 0, "R8 idle x8");
        send(1, 0, '0, 2'd0, 2'd0, 0, "R8 idle x1");
    endtask

    task automatic test_ratio_switch();
        send(0, 1, 20'h9E3A1, 2'd3, 2'd0, 0, "R7 x8 then x1");
        send(0, 1, 20'h4B7D2, 2'd0, 2'd2, 0, "R7 x1 then x4");
        send(0, 1, 20'h6C15E, 2'd2, 2'd2, 0, "R7 x4 after switch");
    endtask

    task automatic test_isolation();
        fork
            begin
                send(0, 1, 20'hF0E1D, 2'd3, 2'd1, 0, "R9 ch0 x8");
                send(0, 1, 20'h12345, 2'd1, 2'd0, 0, "R9 ch0 x2");
            end
            begin
                for (int k = 0; k < 8; k++)
                    send(1, 1, W'(20'h1F3A7 * (k + 3)), 2'd0, 2'd0, 0, "R9 ch1 x1");
            end
        join
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        check("R1 first word", tx_word[0 +: W], '0);
        check("R1 ready after release", W'(in_ready), W'(2'b11));
        test_ratio_sweep();
        test_handshake();
        test_idle();
        test_ratio_switch();
        test_isolation();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule